// File: doc/BRIEF.md
# Byte-Serial Disk Transfer Controller

This block is the processor-facing side of a drive that moves one byte per access between the processor and a disk image. It keeps a head position into a per-side image of up to 65500 bytes. Software reads the data port to pull the byte under the head, which then moves forward. In write mode, software pushes bytes through the same port. A control register selects the direction, rewinds or restarts the head, enables the transfer interrupt and sets the nametable mirroring. A status read reports disk presence and readiness.

Each data read, and certain control writes, start a fixed countdown. When the countdown runs out, the block raises the transfer interrupt if that interrupt is enabled. Software uses this interrupt to pace byte transfers. The disk image sits outside the block behind a single-port synchronous memory interface with a 16-bit address and a one-cycle read latency.

Register map on the 2-bit bus address:
- 0: transfer enable. A write takes bit 0. A read returns the open-bus byte.
- 1: data. A read returns a byte from the disk. A write sends a byte to the disk.
- 2: control on write, status on read.
- 3: auxiliary port, read only.

Every read result appears on `bus_rdata` in the cycle after the read request.

Top module: `disk_xfer_ctrl`

## Requirements
- R1: After reset the interrupt is low, mirroring is high (control is zero) and the head is at 0, so the first data read with a disk returns image byte 0.
- R2: A data read (address 1) with `disk_in` high returns the image byte at the head on `bus_rdata` in the next cycle. The head then moves forward by one.
- R3: The head never passes 64999. A data read at 64999 returns that byte again and leaves the head there.
- R4: A data read with a disk clears the interrupt and loads a 150-cycle countdown. When any countdown reaches zero, `irq` rises on that edge only if control bit 7 is set. Loading the countdown takes priority over its expiry.
- R5: Any control write (address 2) clears the interrupt, unless the countdown expires with bit 7 set on that same edge. With a disk present, bit 1 set moves the head to 0 and loads a 200-cycle countdown. With a disk present, bit 6 set also loads a 200-cycle countdown.
- R6: With a disk present, a control write that clears bit 6 while the old control had bit 6 set, and whose bit 4 is clear, moves the head back by 2 (stopping at 0) and loads a 200-cycle countdown. If the new bit 4 is set, the head does not move.
- R7: With a disk present, a control write with bit 2 clear (write mode) arms a skip count of 2. Each accepted data write decrements a nonzero skip count and stores nothing.
- R8: A data write is accepted only when all of these hold: a disk is present, control bit 2 is clear, enable bit 0 is set and the head is below 65500. An accepted write with a zero skip count and the head at 2 or more drives `mem_we` with `mem_addr` equal to the head minus 2. A data write does not move the head.
- R9: The status read (address 2) has bits 0 and 2 set when no disk is present. Bit 1 is set when no disk is present, when control bit 0 is clear or when control bit 1 is set. Bits 7..3 come from `open_bus`.
- R10: `mirror` is the inverse of control bit 3.
- R11: A read of address 3 returns 0x80. A read of address 0 returns `open_bus`.
- R12: A data read with no disk returns the last byte fetched from the image. It leaves the head, the countdown and the interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the request |
| open_bus | input | 8 | Floating-bus value for undriven read bits |
| disk_in | input | 1 | Disk present |
| mem_addr | output | 16 | Disk image address |
| mem_we | output | 1 | Disk image write strobe |
| mem_wdata | output | 8 | Disk image write data |
| mem_rdata | input | 8 | Disk image read data, one cycle after the address |
| mirror | output | 1 | Nametable mirroring select |
| irq | output | 1 | Transfer interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that the image memory returns the byte addressed on the previous edge. The stimulus issues at most one bus operation per cycle. The bench memory registers its read data on every edge and gives a write the old contents on a same-address read. `disk_in` changes only between operations. This lets the head rewind, the write lag and the no-disk hold all be judged from port values.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

  localparam int unsigned ADDR_W = 16;

  typedef enum logic [1:0] {
    PORT_ENABLE = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_CTRL   = 2'd2,
    PORT_AUX    = 2'd3
  } port_e;

  // only the control bits that later logic reads back are stored
  typedef struct packed {
    logic irq_en;    // bit 7
    logic motor;     // bit 6
    logic mirror;    // bit 3
    logic rd_mode;   // bit 2
    logic head_rst;  // bit 1
    logic xfer;      // bit 0
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] step_head(input logic [ADDR_W-1:0] p,
                                                 input logic [ADDR_W-1:0] cap);
    return (p < cap) ? p + 1'b1 : p;
  endfunction

  function automatic logic [ADDR_W-1:0] back_head(input logic [ADDR_W-1:0] p,
                                                 input logic [ADDR_W-1:0] step);
    return (p >= step) ? p - step : '0;
  endfunction

  function automatic logic rewind_cond(input logic prev_motor, input logic nxt_motor,
                                       input logic nxt_hold);
    return prev_motor && !nxt_motor && !nxt_hold;
  endfunction

  function automatic logic [7:0] status_byte(input logic disk, input ctrl_t c,
                                             input logic [4:0] ob_hi);
    logic [7:0] s;
    s = {ob_hi, 3'b000};
    s[0] = !disk;
    s[2] = !disk;
    s[1] = !disk || !c.xfer || c.head_rst;
    return s;
  endfunction

endpackage

// File: rtl/dxc_head.sv
module dxc_head #(
  parameter int unsigned SIDE_BYTES = 65500,
  parameter int unsigned PTR_MAX    = 64999,
  parameter int unsigned WR_LAG     = 2,
  parameter int unsigned BACK_STEP  = 2,
  parameter int unsigned SKIP_LOAD  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disk_in,
  input  logic                       rd_strobe,
  input  logic                       wr_strobe,
  input  logic                       ctrl_wr,
  input  logic                       prev_motor,
  input  logic                       prev_rd_mode,
  input  logic                       nxt_motor,
  input  logic                       nxt_hold,
  input  logic                       nxt_rd_mode,
  input  logic                       nxt_head_rst,
  input  logic                       en_bit,
  output logic [dxc_pkg::ADDR_W-1:0] head,
  output logic                       mem_we,
  output logic [dxc_pkg::ADDR_W-1:0] mem_addr,
  output logic                       arm_ctrl
);
  localparam int unsigned PW = dxc_pkg::ADDR_W;
  localparam int unsigned SW = $clog2(SKIP_LOAD + 1);
  localparam logic [PW-1:0] SIDE_LIM = PW'(SIDE_BYTES);
  localparam logic [PW-1:0] CAP      = PW'(PTR_MAX);
  localparam logic [PW-1:0] LAG      = PW'(WR_LAG);
  localparam logic [PW-1:0] BACK     = PW'(BACK_STEP);

  logic [PW-1:0] head_q, head_d;
  logic [SW-1:0] skip_q, skip_d;
  logic          ctrl_disk, rewind_hit, wr_accept;

  assign ctrl_disk  = ctrl_wr && disk_in;
  assign rewind_hit = ctrl_disk && dxc_pkg::rewind_cond(prev_motor, nxt_motor, nxt_hold);
  assign wr_accept  = wr_strobe && disk_in && !prev_rd_mode && en_bit && (head_q < SIDE_LIM);
  assign mem_we     = wr_accept && (skip_q == '0) && (head_q >= LAG);
  assign mem_addr   = mem_we ? head_q - LAG : head_q;
  assign arm_ctrl   = ctrl_disk && (rewind_hit || nxt_head_rst || nxt_motor);
  assign head       = head_q;

  always_comb begin
    head_d = head_q;
    if (rd_strobe && disk_in) head_d = dxc_pkg::step_head(head_q, CAP);
    if (ctrl_disk) begin
      if (rewind_hit)   head_d = dxc_pkg::back_head(head_q, BACK);
      if (nxt_head_rst) head_d = '0;
    end
  end

  always_comb begin
    skip_d = skip_q;
    if (ctrl_disk && !nxt_rd_mode)       skip_d = SW'(SKIP_LOAD);
    else if (wr_accept && skip_q != '0)  skip_d = skip_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      skip_q <= '0;
    end else begin
      head_q <= head_d;
      skip_q <= skip_d;
    end
  end
endmodule

// File: rtl/dxc_delay.sv
module dxc_delay #(
  parameter int unsigned READ_DELAY = 150,
  parameter int unsigned CTRL_DELAY = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_read,
  input  logic arm_ctrl,
  input  logic clr,
  input  logic irq_en,
  output logic expire,
  output logic irq
);
  localparam int unsigned MAXD = (READ_DELAY > CTRL_DELAY) ? READ_DELAY : CTRL_DELAY;
  localparam int unsigned CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic          arm_any;

  assign arm_any = arm_read || arm_ctrl;
  assign expire  = (cnt_q == CW'(1)) && !arm_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (arm_ctrl)           cnt_q <= CW'(CTRL_DELAY);
      else if (arm_read)      cnt_q <= CW'(READ_DELAY);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

      if (expire && irq_en)   irq <= 1'b1;
      else if (clr)           irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dxc_rdport.sv
module dxc_rdport #(
  parameter logic [7:0] AUX_VALUE = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [1:0]     addr,
  input  logic           disk_in,
  input  dxc_pkg::ctrl_t ctrl_q,
  input  logic [7:0]     open_bus,
  input  logic [7:0]     mem_rdata,
  output logic [7:0]     rdata
);
  logic [1:0] rsel_q;
  logic       fetched_q;
  logic [7:0] rdata_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel_q    <= '0;
      fetched_q <= 1'b0;
      rdata_q   <= '0;
      last_q    <= '0;
    end else begin
      if (fetched_q) last_q <= mem_rdata;
      fetched_q <= rd_en && (addr == dxc_pkg::PORT_DATA) && disk_in;
      if (rd_en) begin
        rsel_q <= addr;
        case (addr)
          dxc_pkg::PORT_ENABLE: rdata_q <= open_bus;
          dxc_pkg::PORT_CTRL:   rdata_q <= dxc_pkg::status_byte(disk_in, ctrl_q, open_bus[7:3]);
          dxc_pkg::PORT_AUX:    rdata_q <= AUX_VALUE;
          default:              rdata_q <= rdata_q;
        endcase
      end
    end
  end

  assign rdata = (rsel_q == dxc_pkg::PORT_DATA) ? (fetched_q ? mem_rdata : last_q) : rdata_q;
endmodule

// File: rtl/disk_xfer_ctrl.sv
module disk_xfer_ctrl #(
  parameter int unsigned SIDE_BYTES = 65500,
  parameter int unsigned PTR_MAX    = 64999,
  parameter int unsigned WR_LAG     = 2,
  parameter int unsigned BACK_STEP  = 2,
  parameter int unsigned SKIP_LOAD  = 2,
  parameter int unsigned READ_DELAY = 150,
  parameter int unsigned CTRL_DELAY = 200,
  parameter logic [7:0]  AUX_VALUE  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  open_bus,
  input  logic        disk_in,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mirror,
  output logic        irq
);
  dxc_pkg::ctrl_t ctrl_q;
  logic           en_q;
  logic           data_rd, data_wr, ctrl_wr, en_wr;
  logic           arm_ctrl, expire;
  logic [15:0]    head_ptr;

  assign data_rd = bus_rd && (bus_addr == dxc_pkg::PORT_DATA);
  assign data_wr = bus_wr && (bus_addr == dxc_pkg::PORT_DATA);
  assign ctrl_wr = bus_wr && (bus_addr == dxc_pkg::PORT_CTRL);
  assign en_wr   = bus_wr && (bus_addr == dxc_pkg::PORT_ENABLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= '{irq_en: bus_wdata[7], motor: bus_wdata[6], mirror: bus_wdata[3],
                               rd_mode: bus_wdata[2], head_rst: bus_wdata[1], xfer: bus_wdata[0]};
      if (en_wr)   en_q <= bus_wdata[0];
    end
  end

  assign mirror    = !ctrl_q.mirror;
  assign mem_wdata = bus_wdata;

  dxc_head #(
    .SIDE_BYTES(SIDE_BYTES), .PTR_MAX(PTR_MAX), .WR_LAG(WR_LAG),
    .BACK_STEP(BACK_STEP), .SKIP_LOAD(SKIP_LOAD)
  ) u_head (
    .clk(clk), .rst_n(rst_n), .disk_in(disk_in),
    .rd_strobe(data_rd), .wr_strobe(data_wr), .ctrl_wr(ctrl_wr),
    .prev_motor(ctrl_q.motor), .prev_rd_mode(ctrl_q.rd_mode),
    .nxt_motor(bus_wdata[6]), .nxt_hold(bus_wdata[4]),
    .nxt_rd_mode(bus_wdata[2]), .nxt_head_rst(bus_wdata[1]),
    .en_bit(en_q), .head(head_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
    .arm_ctrl(arm_ctrl)
  );

  dxc_delay #(.READ_DELAY(READ_DELAY), .CTRL_DELAY(CTRL_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n),
    .arm_read(data_rd && disk_in), .arm_ctrl(arm_ctrl),
    .clr(ctrl_wr || (data_rd && disk_in)),
    .irq_en(ctrl_q.irq_en), .expire(expire), .irq(irq)
  );

  dxc_rdport #(.AUX_VALUE(AUX_VALUE)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
    .disk_in(disk_in), .ctrl_q(ctrl_q), .open_bus(open_bus),
    .mem_rdata(mem_rdata), .rdata(bus_rdata)
  );
endmodule

// File: rtl/dxc_checker.sv
module dxc_checker #(
  parameter int unsigned PTR_MAX = 64999
) (
  input logic        clk,
  input logic        rst_n,
  input logic        data_rd,
  input logic        data_wr,
  input logic        ctrl_wr,
  input logic        disk_in,
  input logic [15:0] head_ptr,
  input logic        irq_en,
  input logic        rd_mode,
  input logic        en_q,
  input logic        expire,
  input logic        mem_we,
  input logic        irq
);
  AST_HEAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    head_ptr <= 16'(PTR_MAX)); // R3

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && disk_in && (head_ptr < 16'(PTR_MAX)) |=> head_ptr == $past(head_ptr) + 16'd1); // R2

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire) && $past(irq_en)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && disk_in |=> !irq); // R4

  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !(expire && irq_en) |=> !irq); // R5

  AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> data_wr && disk_in && !rd_mode && en_q); // R8

  AST_NODISK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !disk_in |=> head_ptr == $past(head_ptr)); // R12
endmodule

bind disk_xfer_ctrl dxc_checker #(.PTR_MAX(PTR_MAX)) u_dxc_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
  .disk_in(disk_in), .head_ptr(head_ptr), .irq_en(ctrl_q.irq_en),
  .rd_mode(ctrl_q.rd_mode), .en_q(en_q), .expire(expire), .mem_we(mem_we), .irq(irq)
);

// File: tb/test_disk_xfer_ctrl.sv
module test_disk_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, bus_rd, bus_wr, disk_in, mem_we, mirror, irq;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, open_bus, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  always #10 clk = ~clk;

  disk_xfer_ctrl i_disk_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .open_bus(open_bus), .disk_in(disk_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mirror(mirror), .irq(irq)
  );

  // image memory seen by the design, and a shadow copy kept by the model
  logic [7:0] dmem [0:65535];
  logic [7:0] smem [0:65535];

  always @(posedge clk) begin
    if (mem_we) dmem[mem_addr] <= mem_wdata;
    mem_rdata <= dmem[mem_addr];
  end

  int m_ptr, m_skip, m_cnt, m_irq, m_ctrl, m_en, m_last;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic int pat(int i);
    return (i * 7 + (i >> 8) + 3) & 255;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one bus cycle: drive, check the write path, advance the model, check after the edge
  task automatic cyc(input bit rd, input bit wr, input int a, input int d, input string tag);
    int  old, st, armv, exp_rd, exp_ma;
    bit  arm, clr, fire, exp_we, rvalid;
    bus_rd = rd; bus_wr = wr; bus_addr = a[1:0]; bus_wdata = d[7:0];
    #1;
    old = m_ctrl; arm = 0; armv = 0; clr = 0; exp_we = 0; exp_ma = m_ptr; rvalid = 0; exp_rd = 0;
    if (wr && a == 1 && disk_in && !old[2] && m_en[0] && m_ptr < 65500) begin
      if (m_skip > 0) m_skip--;
      else if (m_ptr >= 2) begin exp_we = 1; exp_ma = m_ptr - 2; end
    end
    check(tag, "mem port", {7'd0, mem_we, mem_addr, mem_wdata},
          {7'd0, exp_we, exp_ma[15:0], d[7:0]});
    if (exp_we) smem[exp_ma] = d[7:0];
    if (rd) begin
      rvalid = 1;
      case (a)
        0: exp_rd = open_bus;
        1: if (disk_in) begin
             exp_rd = smem[m_ptr]; m_last = exp_rd;
             if (m_ptr < 64999) m_ptr++;
             arm = 1; armv = 150; clr = 1;
           end else exp_rd = m_last;
        2: begin
             st = open_bus & 'hF8;
             if (!disk_in) st |= 7;
             else if (!old[0] || old[1]) st |= 2;
             exp_rd = st;
           end
        default: exp_rd = 'h80;
      endcase
    end
    if (wr && a == 2) begin
      clr = 1;
      if (disk_in) begin
        if (!d[6] && old[6] && !d[4]) begin m_ptr = (m_ptr >= 2) ? m_ptr - 2 : 0; arm = 1; end
        if (!d[2]) m_skip = 2;
        if (d[1]) begin m_ptr = 0; arm = 1; end
        if (d[6]) arm = 1;
        if (arm) armv = 200;
      end
      m_ctrl = d & 255;
    end
    if (wr && a == 0) m_en = d & 1;
    fire  = (m_cnt == 1) && !arm;
    m_cnt = arm ? armv : ((m_cnt > 0) ? m_cnt - 1 : 0);
    if (fire && old[7]) m_irq = 1;
    else if (clr) m_irq = 0;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    check(tag, "irq", {31'd0, irq}, m_irq);
    check(tag, "mirror", {31'd0, mirror}, (m_ctrl >> 3) & 1 ? 0 : 1);
    if (rvalid) check(tag, "rdata", {24'd0, bus_rdata}, exp_rd);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin dmem[i] = 8'(pat(i)); smem[i] = 8'(pat(i)); end
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; open_bus = 0; disk_in = 0;
    m_ptr = 0; m_skip = 0; m_cnt = 0; m_irq = 0; m_ctrl = 0; m_en = 0; m_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", "irq", {31'd0, irq}, 0);
    check("R1", "mirror", {31'd0, mirror}, 1);
    disk_in = 1;
    cyc(1, 0, 1, 0, "R1");                 // byte 0 proves head at 0
    cyc(1, 0, 3, 0, "R11");
    open_bus = 8'h5A;
    cyc(1, 0, 0, 0, "R11");
    disk_in = 0; open_bus = 8'hA8;
    cyc(1, 0, 2, 0, "R9");
    disk_in = 1;
    cyc(0, 1, 2, 'h05, "R10");
    cyc(1, 0, 2, 0, "R9");
    cyc(0, 1, 2, 'h07, "R5");              // head to 0, 200-cycle countdown
    cyc(1, 0, 2, 0, "R9");
    cyc(0, 1, 2, 'h85, "R5");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, "R2");
    idle(160, "R4");                        // irq at 150 cycles
    cyc(0, 1, 2, 'h05, "R5");              // clears irq
    cyc(0, 1, 2, 'h0D, "R10");
    cyc(0, 1, 2, 'h05, "R10");
    cyc(1, 0, 1, 0, "R2");
    idle(160, "R4");                        // enable clear: no irq
    cyc(0, 1, 2, 'hC5, "R5");
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, "R6");
    cyc(0, 1, 2, 'h85, "R6");              // rewind by 2
    cyc(1, 0, 1, 0, "R6");
    idle(210, "R5");
    cyc(0, 1, 2, 'hC5, "R6");
    cyc(0, 1, 2, 'h95, "R6");              // hold bit set: no rewind
    cyc(1, 0, 1, 0, "R6");
    cyc(0, 1, 0, 1, "R8");
    cyc(0, 1, 2, 'h87, "R8");
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, "R8");
    cyc(0, 1, 2, 'hC1, "R7");              // write mode, skip 2
    cyc(0, 1, 1, 'h11, "R7");
    cyc(0, 1, 1, 'h22, "R7");
    cyc(0, 1, 1, 'h33, "R8");
    cyc(0, 1, 1, 'h44, "R8");
    cyc(0, 1, 0, 0, "R8");
    cyc(0, 1, 1, 'h55, "R8");              // enable clear: ignored
    cyc(0, 1, 0, 1, "R8");
    cyc(0, 1, 2, 'h87, "R8");
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, "R8");
    cyc(0, 1, 2, 'hC3, "R8");              // head 0, write mode
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 'h66 + i, "R8");
    cyc(0, 1, 2, 'hC5, "R8");
    cyc(0, 1, 1, 'h77, "R8");              // read mode: ignored
    cyc(0, 1, 2, 'h87, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, "R8");
    cyc(1, 0, 1, 0, "R12");
    disk_in = 0;
    cyc(1, 0, 1, 0, "R12");
    cyc(1, 0, 1, 0, "R12");
    idle(5, "R12");
    disk_in = 1;
    cyc(1, 0, 1, 0, "R12");
    cyc(0, 1, 2, 'h07, "R3");
    for (int i = 0; i < 65003; i++) cyc(1, 0, 1, 0, "R3");
    for (int i = 0; i < 2000; i++) begin
      int op;
      op = $urandom_range(0, 2);
      open_bus = 8'($urandom);
      if ($urandom_range(0, 15) == 0) disk_in = !disk_in;
      cyc(op == 1, op == 2, $urandom_range(0, 3), $urandom_range(0, 255), "R2");
    end
    summary();
  end
endmodule